// File: doc/BRIEF.md
# Trigger Veto Conditioner

This block produces the signal that holds off acquisition triggers in a digitizer. A small set of asynchronous veto lines is brought into the clock domain, and a per-line enable mask selects which lines take part. The enabled lines are combined by OR. The combined level can act as an inhibit, where triggers are blocked while it is asserted. It can also act as a gate, where triggers pass only while it is asserted. A retriggerable stretcher can hold the veto for a programmable number of clock ticks after each assertion.

The polarity and the stretch width are register inputs that the block captures on a load strobe. They can therefore be retuned during a run without disturbing a stretch that is already counting. The enable mask is applied as presented. The gated trigger leaves the block through a single output register.

Top module: `veto_conditioner`

## Requirements
- R1: While reset is low, and after reset until the first load, `veto_active` and `trig_out` are 0. The captured polarity is inhibit and the captured width is 0.
- R2: Each `veto_src_in` bit passes through a two-flop synchroniser. The synchronised bits whose `src_enable` bit is 1 are ORed together.
- R3: A line whose `src_enable` bit is 0 has no effect. With `src_enable` all zero, `veto_active` stays 0 in both polarities.
- R4: With the captured polarity 0 (inhibit), the veto is asserted while any enabled synchronised line is 1.
- R5: With the captured polarity 1 (gate), the veto is asserted while at least one line is enabled and no enabled synchronised line is 1.
- R6: With a captured width of 0, `veto_active` follows the combined level exactly.
- R7: With a captured width W>0, a rising edge of the combined level holds `veto_active` for at least W clocks, counting the edge cycle. The veto lasts longer if the level stays asserted longer.
- R8: A new rising edge of the combined level while a stretch is running restarts the full width W.
- R9: `gate_mode` and `stretch_ticks` are captured only in a cycle with `cfg_load` high, and take effect from the next clock. When `cfg_load` is low, changes on them have no effect.
- R10: Loading a new width while a stretch is counting does not shorten or lengthen that stretch, even when the new width is 0.
- R11: `trig_out` equals `trig_in AND NOT veto_active` as sampled at the previous clock edge, which gives one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one tick = one width step) |
| rst_n | input | 1 | Active-low synchronous reset |
| veto_src_in | input | NUM_SRC | Asynchronous veto lines |
| src_enable | input | NUM_SRC | Per-line participation mask |
| gate_mode | input | 1 | Polarity to capture: 0 inhibit, 1 gate |
| stretch_ticks | input | TICK_W | Stretch width to capture, in clock ticks |
| cfg_load | input | 1 | Capture strobe for polarity and width |
| trig_in | input | 1 | Incoming trigger strobe |
| veto_active | output | 1 | Conditioned veto |
| trig_out | output | 1 | Trigger after veto, registered |

## Verification
The bench covers four cases where a wrong design behaves visibly differently:

- **Gate polarity with nothing enabled.** A design that inverts the combined level without checking the mask would veto every trigger.
- **Retrigger.** A non-retriggerable stretcher would end after the first width instead of gap plus width.
- **Long held source.** A fixed-length monostable would drop the veto while the source is still asserted.
- **Width reload to zero during a stretch.** A design that reads the live width would cut the veto short.

The bench also drives width changes without the strobe, which must have no effect, and checks the one-clock trigger latency on both sides of the edge.

// File: rtl/veto_conditioner.sv
module veto_conditioner #(
  parameter int NUM_SRC = 4,
  parameter int TICK_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] veto_src_in,
  input  logic [NUM_SRC-1:0] src_enable,
  input  logic               gate_mode,
  input  logic [TICK_W-1:0]  stretch_ticks,
  input  logic               cfg_load,
  input  logic               trig_in,
  output logic               veto_active,
  output logic               trig_out
);

  logic [NUM_SRC-1:0] meta_q, sync_q;
  logic               pol_q, lvl_d;
  logic [TICK_W-1:0]  width_q, cnt_q;
  logic               any_hit, level, rise, stretching;

  assign any_hit    = |(sync_q & src_enable);
  assign level      = (|src_enable) & (pol_q ? ~any_hit : any_hit);
  assign rise       = level & ~lvl_d;
  assign stretching = (cnt_q != '0);
  assign veto_active = level | stretching;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_q   <= '0;
      lvl_d    <= 1'b0;
      pol_q    <= 1'b0;
      width_q  <= '0;
      cnt_q    <= '0;
      trig_out <= 1'b0;
    end else begin
      meta_q   <= veto_src_in;
      sync_q   <= meta_q;
      lvl_d    <= level;
      trig_out <= trig_in & ~veto_active;
      if (cfg_load) begin
        pol_q   <= gate_mode;
        width_q <= stretch_ticks;
      end
      if (rise && width_q != '0)
        cnt_q <= width_q - TICK_W'(1);
      else if (stretching)
        cnt_q <= cnt_q - TICK_W'(1);
    end
  end

endmodule

// File: rtl/veto_conditioner_checks.sv
module veto_conditioner_checks #(
  parameter int TICK_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_in,
  input logic              trig_out,
  input logic              veto_active,
  input logic              cfg_load,
  input logic              pol_q,
  input logic [TICK_W-1:0] width_q,
  input logic [TICK_W-1:0] cnt_q,
  input logic              rise
);

  p_trig_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> trig_out == $past(trig_in && !veto_active));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(pol_q) && $stable(width_q)));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && width_q != '0) |=> cnt_q == $past(width_q) - TICK_W'(1));

  p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !(rise && width_q != '0)) |=> cnt_q == $past(cnt_q) - TICK_W'(1));

  p_stretch_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> veto_active);

endmodule

bind veto_conditioner veto_conditioner_checks #(.TICK_W(TICK_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out(trig_out),
  .veto_active(veto_active), .cfg_load(cfg_load), .pol_q(pol_q),
  .width_q(width_q), .cnt_q(cnt_q), .rise(rise)
);

// File: tb/veto_conditioner_bench.sv
`timescale 1ns/1ps
module veto_conditioner_bench;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  veto_src_in = '0, src_enable = '0;
  logic        gate_mode = 0, cfg_load = 0, trig_in = 0;
  logic [31:0] stretch_ticks = '0;
  logic        veto_active, trig_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  veto_conditioner u_veto_conditioner (.*);

  // {enable[3:0], src[3:0], gate, trig, expected_veto}
  localparam logic [10:0] VEC [9] = '{
    {4'b0001, 4'b0001, 1'b0, 1'b1, 1'b1},  // R4
    {4'b0001, 4'b0000, 1'b0, 1'b1, 1'b0},  // R4
    {4'b0110, 4'b0100, 1'b0, 1'b1, 1'b1},  // R2
    {4'b0110, 4'b1001, 1'b0, 1'b1, 1'b0},  // R3
    {4'b0000, 4'b1111, 1'b0, 1'b1, 1'b0},  // R3
    {4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0},  // R3
    {4'b0011, 4'b0010, 1'b1, 1'b1, 1'b0},  // R5
    {4'b0011, 4'b0000, 1'b1, 1'b0, 1'b1},  // R5
    {4'b1000, 4'b0111, 1'b1, 1'b1, 1'b1}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic g, input logic [31:0] w);
    @(negedge clk);
    gate_mode = g; stretch_ticks = w; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  // Pulses line 0, optionally a second pulse, optionally a width reload; counts veto cycles.
  task automatic measure(input int hold1, input int gap, input int hold2,
                         input int chg_at, output int cnt);
    cnt = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      veto_src_in[0] = (i < hold1) || (gap > 0 && i >= gap && i < gap + hold2);
      cfg_load = (i == chg_at);
      if (i == chg_at) stretch_ticks = 0;
      #1;
      if (veto_active) cnt++;
    end
    cfg_load = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    trig_in = 1; veto_src_in = 4'b1111; src_enable = 4'b1111;
    repeat (3) @(negedge clk);
    check("R1 veto in reset", veto_active, 0);
    check("R1 trig in reset", trig_out, 0);
    @(negedge clk); rst_n = 1; veto_src_in = '0; src_enable = '0; trig_in = 0;
    @(negedge clk);
    check("R1 veto after reset", veto_active, 0);

    for (int v = 0; v < 9; v++) begin
      load_cfg(VEC[v][2], 0);
      src_enable = VEC[v][10:7]; veto_src_in = VEC[v][6:3]; trig_in = VEC[v][1];
      repeat (4) @(negedge clk);
      check($sformatf("R2-vec%0d veto", v), veto_active, VEC[v][0]);
      check($sformatf("R11-vec%0d trig", v), trig_out, VEC[v][1] & ~VEC[v][0]);
    end

    load_cfg(0, 0);
    src_enable = 4'b0001; veto_src_in = '0; trig_in = 0;
    repeat (4) @(negedge clk);
    trig_in = 1; #1;
    check("R11 latency before edge", trig_out, 0);
    @(negedge clk);
    check("R11 latency after edge", trig_out, 1);
    trig_in = 0;

    measure(1, 0, 0, -1, n);  check("R6 width zero follows source", n, 1);
    load_cfg(0, 5);
    measure(1, 0, 0, -1, n);  check("R7 single pulse stretch", n, 5);
    load_cfg(0, 3);
    measure(8, 0, 0, -1, n);  check("R7 held source exceeds width", n, 8);
    load_cfg(0, 10);
    measure(1, 3, 1, -1, n);  check("R8 retrigger restarts width", n, 13);
    load_cfg(0, 12);
    measure(1, 0, 0, 4, n);   check("R10 reload during stretch", n, 12);
    stretch_ticks = 20;
    measure(1, 0, 0, -1, n);  check("R9 width ignored without load", n, 1);
    gate_mode = 1; src_enable = 4'b0001; veto_src_in = 4'b0001;
    repeat (4) @(negedge clk);
    check("R9 polarity ignored without load", veto_active, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule